// File: doc/BRIEF.md
# Programmable Butterfly Bit-Pattern Unit

This block pushes a data word through a log2(width)-stage butterfly network. Stage s pairs every bit j with the bit at j XOR 2^s. When that stage is switched on, each bit is replaced by a 2-input lookup of itself and its partner. The six enable bits of the default 64-bit build are the low bits of a second operand. The stages run from the smallest stride to the largest. A disabled stage passes its word through untouched.

The same datapath covers three operations. A swap lookup gives a generalized bit reverse. An OR lookup gives a generalized OR-combine. Any other 4-bit lookup produces other regular patterns, and with a zero data word the lookup alone can generate constant masks.

A mode input picks the operation. Mode 0 forces the swap code and mode 1 forces the OR code. Modes 2 and 3 apply the caller's 4-bit code as given. The result is registered once, qualified by a valid strobe.

Top module: `grevlut_unit`

## Requirements
- R1: Only bits [5:0] of `opb` control the stages; bit s enables the stage of stride 2^s. Bits [63:6] of `opb` have no effect on `result`.
- R2: The stages run in the order of strides 1, 2, 4, 8, 16, 32. In an enabled stage with code C, output bit j = C[{partner, self}], where self = x[j], partner = x[j XOR stride] and bits are numbered from the LSB. This gives index 0 for (partner 0, self 0), index 1 for (partner 0, self 1), index 2 for (partner 1, self 0) and index 3 for (partner 1, self 1).
- R3: A stage whose enable bit is 0 passes its data unchanged, so a control value of 0 returns `opa` in every mode.
- R4: Mode 2'd0 (swap) uses code 4'b1100. `result` is a bit permutation of `opa`, and control 63 reverses all 64 bits.
- R5: Mode 2'd1 (OR-combine) uses code 4'b1110. Every bit set in `opa` stays set in `result`, and control 63 turns any nonzero `opa` into all ones.
- R6: Modes 2'd2 and 2'd3 use `lut_code[3:0]` directly. Code 4'b1010 returns `opa`, code 4'b0000 gives zero for any nonzero control, and code 4'b0101 inverts the word in any enabled stage.
- R7: With `opa` zero, the result depends only on the code and the control. For example, code 4'b0001 with control 1 gives all ones, and with control 3 it gives zero.
- R8: `result` and `out_valid` update one clock after `in_valid` is sampled high. In a cycle after `in_valid` is sampled low, `out_valid` is 0 and `result` holds its value.
- R9: While `rst_n` is low, `out_valid` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| opa | input | 64 | Data word fed into the network |
| opb | input | 64 | Control operand; low 6 bits enable the stages |
| lut_code | input | 4 | Lookup code used in modes 2 and 3 |
| mode | input | 2 | 0 swap, 1 OR-combine, 2 or 3 raw lookup |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered network output |

## Verification
On every sampled operation, the assertions check:
- in swap mode, the population count is preserved;
- in OR-combine mode, the result is a superset of the input;
- a zero control returns the input exactly;
- in raw mode, an all-zero code clears the word;
- the one-cycle result and valid timing, and the hold behaviour between operations.

These properties are necessary but not sufficient, so only the bench's scenarios can show the exact bit positions. Those scenarios include the full 64-bit reversal, the filling pattern of OR-combine, the order in which stages are applied, the masking of the upper control bits, and the constant patterns produced from a zero data word. The bench compares each of them against a separately written model.

// File: rtl/grl_pkg.sv
package grl_pkg;
  typedef enum logic [1:0] {
    GRL_SWAP  = 2'd0,
    GRL_ORC   = 2'd1,
    GRL_RAW   = 2'd2,
    GRL_RAW_B = 2'd3
  } grl_mode_e;

  localparam logic [3:0] SWAP_CODE = 4'b1100;
  localparam logic [3:0] ORC_CODE  = 4'b1110;
endpackage

// File: rtl/grl_code_sel.sv
module grl_code_sel
  import grl_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [3:0] lut_code,
  output logic [3:0] code
);
  grl_mode_e m;

  always_comb begin
    m = grl_mode_e'(mode);
    unique case (m)
      GRL_SWAP: code = SWAP_CODE;
      GRL_ORC:  code = ORC_CODE;
      default:  code = lut_code;
    endcase
  end
endmodule

// File: rtl/grl_stage.sv
module grl_stage #(
  parameter int W      = 64,
  parameter int STRIDE = 1
) (
  input  logic         en,
  input  logic [3:0]   code,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam int PART = j ^ STRIDE;
    logic [1:0] idx;
    assign idx  = {x[PART], x[j]};
    assign y[j] = en ? code[idx] : x[j];
  end
endmodule

// File: rtl/grl_butterfly.sv
module grl_butterfly #(
  parameter int W      = 64,
  parameter int NSTAGE = $clog2(W)
) (
  input  logic [NSTAGE-1:0] ctrl,
  input  logic [3:0]        code,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout
);
  logic [W-1:0] chain [NSTAGE+1];

  assign chain[0] = din;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    grl_stage #(.W(W), .STRIDE(1 << s)) i_stage (
      .en   (ctrl[s]),
      .code (code),
      .x    (chain[s]),
      .y    (chain[s+1])
    );
  end

  assign dout = chain[NSTAGE];
endmodule

// File: rtl/grevlut_unit.sv
module grevlut_unit
  import grl_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [3:0]        lut_code,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int          CTRL_W   = $clog2(DATA_W);
  localparam [DATA_W-1:0] CTRL_MSK = DATA_W'((1 << CTRL_W) - 1);

  logic [CTRL_W-1:0] ctrl;
  logic [3:0]        code;
  logic [DATA_W-1:0] net_out;
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;

  assign ctrl = opb[CTRL_W-1:0];

  grl_code_sel i_code_sel (
    .mode     (mode),
    .lut_code (lut_code),
    .code     (code)
  );

  grl_butterfly #(.W(DATA_W), .NSTAGE(CTRL_W)) i_net (
    .ctrl (ctrl),
    .code (code),
    .din  (opa),
    .dout (net_out)
  );

  // next state: capture only when an operation is presented
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? net_out : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  // R4: swap mode only moves bits around
  p_swap_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0) |-> ($countones(net_out) == $countones(opa)));

  // R5: OR-combine never clears a bit
  p_orc_super_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1) |-> ((net_out & opa) == opa));

  // R3: zero control (upper opb bits ignored, R1) is the identity
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opb & CTRL_MSK) == '0) |-> (net_out == opa));

  // R6: all-zero raw code clears the word once any stage runs
  p_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && lut_code == 4'b0000 && ctrl != '0) |-> (net_out == '0));

  // R8: one-cycle capture
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && result == $past(net_out)));

  // R8: hold between operations
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
endmodule

// File: tb/test_grevlut_unit.sv
module test_grevlut_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] opa, opb;
  logic [3:0]  lut_code;
  logic [1:0]  mode;
  logic        out_valid;
  logic [63:0] result;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_vec  = 0;
  int          n_fail = 0;
  logic [63:0] last_res;
  bit          done   = 0;

  always #10 clk = ~clk;

  grevlut_unit i_grevlut_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .lut_code(lut_code), .mode(mode), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                        logic [3:0] l, logic [1:0] m);
    logic [3:0]  c;
    logic [63:0] x, y;
    c = (m == 2'd0) ? 4'b1100 : (m == 2'd1) ? 4'b1110 : l;
    x = a;
    for (int s = 0; s < 6; s++) begin
      if (b[s]) begin
        for (int j = 0; j < 64; j++) y[j] = c[{x[j ^ (1 << s)], x[j]}];
        x = y;
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] bitrev(logic [63:0] a);
    logic [63:0] r;
    for (int j = 0; j < 64; j++) r[j] = a[63-j];
    return r;
  endfunction

  task automatic fail(string tag, logic [63:0] act, logic [63:0] exp);
    n_fail++;
    $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic apply(logic [63:0] a, logic [63:0] b, logic [3:0] l,
                       logic [1:0] m, logic [63:0] exp, string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; opa = a; opb = b; lut_code = l; mode = m;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    opa = 64'hDEAD_BEEF_0BAD_F00D;
    opb = 64'h3F;
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (rst_n === 1'b1) begin
        if (out_valid) begin
          n_vec++;
          if (sb.size() == 0) fail("R8 unexpected valid", result, 64'h0);
          else begin
            it = sb.pop_front();
            if (result !== it.exp) fail(it.tag, result, it.exp);
          end
        end else if (result !== last_res) begin
          n_vec++;
          fail("R8 hold", result, last_res);
        end
        last_res = result;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [3:0]  l;
    logic [1:0]  m;
    rst_n = 1'b0; in_valid = 1'b0; opa = '0; opb = '0; lut_code = '0; mode = '0;
    last_res = '0;
    repeat (3) @(posedge clk);
    #5;
    n_vec++;
    if (out_valid !== 1'b0 || result !== 64'h0) fail("R9 reset", result, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: zero control returns opa in each mode
    for (int k = 0; k < 4; k++)
      apply(64'h0123_4567_89AB_CDEF, 64'h0, 4'h3, 2'(k), 64'h0123_4567_89AB_CDEF, "R3 pass");
    // R1: upper control bits ignored
    apply(64'hF0F0_1234_0000_FFFF, 64'hFFFF_FFFF_FFFF_FFC0, 4'h0, 2'd0,
          64'hF0F0_1234_0000_FFFF, "R1 upper bits");
    apply(64'h1, 64'hABCD_0000_0000_0001, 4'h0, 2'd0, 64'h2, "R1 stride1 swap");
    // R4: full reversal
    a = 64'h8000_0000_0000_0013;
    apply(a, 64'd63, 4'h0, 2'd0, bitrev(a), "R4 full reverse");
    a = 64'h0123_4567_89AB_CDEF;
    apply(a, 64'd63, 4'h9, 2'd0, bitrev(a), "R4 full reverse");
    idle();
    // R5: OR-combine
    apply(64'h1, 64'd63, 4'h0, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 fill");
    apply(64'h100, 64'd7, 4'h0, 2'd1, 64'hFF00, "R5 byte fill");
    // R6: raw codes
    apply(a, 64'd63, 4'hA, 2'd2, a, "R6 identity code");
    apply(a, 64'd5, 4'h0, 2'd3, 64'h0, "R6 zero code");
    apply(a, 64'd1, 4'h5, 2'd2, ~a, "R6 invert code");
    idle();
    idle();
    // R7: constant patterns from zero data
    apply(64'h0, 64'd1, 4'h1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R7 const ones");
    apply(64'h0, 64'd3, 4'h1, 2'd3, 64'h0, "R7 const zero");
    apply(64'h0, 64'd63, 4'h9, 2'd2, model(64'h0, 64'd63, 4'h9, 2'd2), "R7 const pattern");

    // R2: random operands against the model, with gaps for R8
    for (int k = 0; k < 400; k++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      l = 4'($urandom);
      m = 2'($urandom);
      apply(a, b, l, m, model(a, b, l, m), "R2 random");
      if ($urandom_range(0, 4) == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R8: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule